// File: doc/BRIEF.md
# Two-Slot Received Frame Queue

This block sits between a CAN receive engine and the CPU-facing register file. When the receiver finishes a frame it presents the frame's info word, its identifier and its two 32-bit payload words for one cycle on the write port. The block keeps up to two such frames in arrival order. It always shows the oldest unreleased frame on its read port, so software can read the fields straight from the outputs.

Software frees the frame it has finished reading with a one-cycle release pulse, and the next waiting frame then moves to the read port. A frame that arrives while both slots are in use is thrown away and a sticky overrun flag records the loss. Only a one-cycle clear pulse lowers that flag. A second flag tells software that at least one frame is waiting.

Top module: `rxq_top`

## Requirements
- R1: After reset, rx_avail and rx_overrun are both 0.
- R2: A wr_valid pulse into an empty queue makes rx_avail 1 on the next cycle, and the read port then shows that frame's info, identifier and both data words.
- R3: Frames leave in the order they arrived. The read port always shows the oldest frame not yet released, and a release moves the next frame onto it in the following cycle.
- R4: A release lowers rx_avail only when it frees the last stored frame. When a second frame is waiting, rx_avail stays 1.
- R5: A frame that arrives with both slots full, and no release in the same cycle, is dropped. rx_overrun is 1 on the next cycle, and the stored frames and their order do not change.
- R6: rx_overrun stays 1 through writes, releases and idle cycles until a clr_ovr_cmd pulse, and it reads 0 in the cycle after that pulse.
- R7: A release while the queue is empty has no effect. rx_avail stays 0, rx_overrun does not change, and the next written frame appears normally.
- R8: When wr_valid and rel_cmd come in the same cycle with both slots full, the release is handled first. The new frame is stored behind the remaining one and rx_overrun is not set.
- R9: If a dropped frame and a clr_ovr_cmd pulse fall in the same cycle, the drop wins and rx_overrun is 1 afterwards.
- R10: While the queue holds a frame and no release is given, the read port outputs do not change, whatever arrives on the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe: a completed frame is on the wr_* inputs |
| wr_info | input | 16 | Frame info word (length, format and similar) of the incoming frame |
| wr_id | input | 29 | Identifier of the incoming frame |
| wr_data_lo | input | 32 | First payload word of the incoming frame |
| wr_data_hi | input | 32 | Second payload word of the incoming frame |
| rel_cmd | input | 1 | One-cycle release of the oldest stored frame |
| clr_ovr_cmd | input | 1 | One-cycle clear of the overrun flag |
| rd_info | output | 16 | Info word of the oldest stored frame |
| rd_id | output | 29 | Identifier of the oldest stored frame |
| rd_data_lo | output | 32 | First payload word of the oldest stored frame |
| rd_data_hi | output | 32 | Second payload word of the oldest stored frame |
| rx_avail | output | 1 | 1 while at least one frame is stored |
| rx_overrun | output | 1 | Sticky 1 once a frame has been dropped for lack of space |

## Verification
A wrong fill count shows on rx_avail within one cycle of the release that should have emptied the queue, or as an overrun flagged after only one stored frame. A wrong head or tail pointer shows the next time a frame moves onto the read port: a release brings up the wrong identifier, or a dropped frame overwrites one that is visible. Each scenario gives its frames unique field values, so a misplaced frame is caught at the first read that follows.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int INFO_W = 16;
  localparam int ID_W   = 29;
  localparam int WORD_W = 32;

  typedef int unsigned idx_t;

  typedef struct packed {
    logic [INFO_W-1:0] info;
    logic [ID_W-1:0]   id;
    logic [WORD_W-1:0] lo;
    logic [WORD_W-1:0] hi;
  } rx_frame_t;

  // slot reached by stepping 'off' places forward from 'base' in a ring of 'slots'
  function automatic idx_t slot_after(idx_t base, idx_t off, idx_t slots);
    return (base + off) % slots;
  endfunction

  // occupancy after one cycle with an optional store and an optional free
  function automatic idx_t fill_next(idx_t fill, logic take, logic give);
    return fill + idx_t'(take) - idx_t'(give);
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int PTR_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] wptr,
  input  rx_frame_t        wframe,
  input  logic [PTR_W-1:0] rptr,
  output rx_frame_t        rframe
);
  rx_frame_t slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rx_frame_t cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           cell_q <= '0;
      else if (we && (wptr == PTR_W'(g)))   cell_q <= wframe;
    end
    assign slot_q[g] = cell_q;
  end

  assign rframe = slot_q[rptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int PTR_W = 1,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             rel_cmd,
  input  logic             clr_ovr_cmd,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] fill,
  output logic             wr_acc,
  output logic             wr_drop,
  output logic             rel_eff,
  output logic             avail,
  output logic             overrun
);
  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] fill_q;
  logic             ovr_q;

  // release is served before the write, so a full queue can swap in one cycle
  assign rel_eff = rel_cmd && (fill_q != '0);
  assign wr_acc  = wr_valid && ((idx_t'(fill_q) < idx_t'(SLOTS)) || rel_eff);
  assign wr_drop = wr_valid && !wr_acc;
  assign tail    = PTR_W'(slot_after(idx_t'(head_q), idx_t'(fill_q), idx_t'(SLOTS)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      fill_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      fill_q <= CNT_W'(fill_next(idx_t'(fill_q), wr_acc, rel_eff));
      if (rel_eff)
        head_q <= PTR_W'(slot_after(idx_t'(head_q), 1, idx_t'(SLOTS)));
      if (wr_drop)          ovr_q <= 1'b1;
      else if (clr_ovr_cmd) ovr_q <= 1'b0;
    end
  end

  assign head    = head_q;
  assign fill    = fill_q;
  assign avail   = (fill_q != '0);
  assign overrun = ovr_q;
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [INFO_W-1:0] wr_info,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [WORD_W-1:0] wr_data_lo,
  input  logic [WORD_W-1:0] wr_data_hi,
  input  logic              rel_cmd,
  input  logic              clr_ovr_cmd,
  output logic [INFO_W-1:0] rd_info,
  output logic [ID_W-1:0]   rd_id,
  output logic [WORD_W-1:0] rd_data_lo,
  output logic [WORD_W-1:0] rd_data_hi,
  output logic              rx_avail,
  output logic              rx_overrun
);
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] fill;
  logic             wr_acc, wr_drop, rel_eff;
  rx_frame_t        in_frame, out_frame;

  assign in_frame = '{info: wr_info, id: wr_id, lo: wr_data_lo, hi: wr_data_hi};

  rxq_ctrl #(.SLOTS(SLOTS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .rel_cmd     (rel_cmd),
    .clr_ovr_cmd (clr_ovr_cmd),
    .head        (head),
    .tail        (tail),
    .fill        (fill),
    .wr_acc      (wr_acc),
    .wr_drop     (wr_drop),
    .rel_eff     (rel_eff),
    .avail       (rx_avail),
    .overrun     (rx_overrun)
  );

  rxq_store #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_acc),
    .wptr   (tail),
    .wframe (in_frame),
    .rptr   (head),
    .rframe (out_frame)
  );

  assign rd_info    = out_frame.info;
  assign rd_id      = out_frame.id;
  assign rd_data_lo = out_frame.lo;
  assign rd_data_hi = out_frame.hi;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int SLOTS = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             rel_cmd,
  input logic             clr_ovr_cmd,
  input logic [28:0]      rd_id,
  input logic [31:0]      rd_data_lo,
  input logic             rx_avail,
  input logic             rx_overrun,
  input logic [CNT_W-1:0] fill,
  input logic             wr_drop,
  input logic             rel_eff
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !rx_avail && !rx_overrun); // R1
  AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |=> rx_avail); // R2
  AST_LAST_FREE: assert property (@(posedge clk) disable iff (!rst_n) rel_cmd && !wr_valid && fill == CNT_W'(1) |=> !rx_avail); // R4
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) wr_drop |=> rx_overrun); // R5
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) int'(fill) <= SLOTS); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rx_overrun && !clr_ovr_cmd |=> rx_overrun); // R6
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_ovr_cmd && !wr_drop |=> !rx_overrun); // R6
  AST_EMPTY_REL: assert property (@(posedge clk) disable iff (!rst_n) rel_cmd && !rx_avail && !wr_valid |=> !rx_avail && $stable(rx_overrun)); // R7
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n) wr_valid && rel_cmd && int'(fill) == SLOTS |-> !wr_drop && rel_eff); // R8
  AST_DROP_WINS: assert property (@(posedge clk) disable iff (!rst_n) wr_drop && clr_ovr_cmd |=> rx_overrun); // R9
  AST_HEAD_STEADY: assert property (@(posedge clk) disable iff (!rst_n) rx_avail && !rel_cmd |=> $stable(rd_id) && $stable(rd_data_lo)); // R10
endmodule

bind rxq_top rxq_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .rel_cmd     (rel_cmd),
  .clr_ovr_cmd (clr_ovr_cmd),
  .rd_id       (rd_id),
  .rd_data_lo  (rd_data_lo),
  .rx_avail    (rx_avail),
  .rx_overrun  (rx_overrun),
  .fill        (fill),
  .wr_drop     (wr_drop),
  .rel_eff     (rel_eff)
);

// File: tb/tb_rxq_top.sv
module tb_rxq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_info = '0;
  logic [28:0] wr_id = '0;
  logic [31:0] wr_data_lo = '0, wr_data_hi = '0;
  logic        rel_cmd = 1'b0, clr_ovr_cmd = 1'b0;
  logic [15:0] rd_info;
  logic [28:0] rd_id;
  logic [31:0] rd_data_lo, rd_data_hi;
  logic        rx_avail, rx_overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rxq_top dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_info(wr_info), .wr_id(wr_id),
    .wr_data_lo(wr_data_lo), .wr_data_hi(wr_data_hi), .rel_cmd(rel_cmd),
    .clr_ovr_cmd(clr_ovr_cmd), .rd_info(rd_info), .rd_id(rd_id), .rd_data_lo(rd_data_lo),
    .rd_data_hi(rd_data_hi), .rx_avail(rx_avail), .rx_overrun(rx_overrun)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock; inputs change and outputs are sampled 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
    wr_valid = 1'b0; rel_cmd = 1'b0; clr_ovr_cmd = 1'b0;
  endtask

  task automatic put(int n);
    wr_valid = 1'b1;
    wr_info = 16'(16'h0800 + n);
    wr_id = 29'(29'h1ABC000 + n);
    wr_data_lo = 32'hD0D00000 + n;
    wr_data_hi = 32'hE1E10000 + n;
  endtask

  task automatic expect_head(string req, int n);
    check(req, "info", 64'(rd_info), 64'(16'h0800 + n));
    check(req, "id", 64'(rd_id), 64'(29'h1ABC000 + n));
    check(req, "lo", 64'(rd_data_lo), 64'(32'hD0D00000 + n));
    check(req, "hi", 64'(rd_data_hi), 64'(32'hE1E10000 + n));
  endtask

  task automatic t_reset();
    check("R1", "avail", 64'(rx_avail), 64'd0);
    check("R1", "overrun", 64'(rx_overrun), 64'd0);
  endtask

  task automatic t_order();
    put(1); tick();
    check("R2", "avail", 64'(rx_avail), 64'd1);
    expect_head("R2", 1);
    put(2); tick();
    expect_head("R10", 1);
    tick(); tick();
    expect_head("R10", 1);
    rel_cmd = 1'b1; tick();
    expect_head("R3", 2);
    check("R4", "avail after partial release", 64'(rx_avail), 64'd1);
    rel_cmd = 1'b1; tick();
    check("R4", "avail after last release", 64'(rx_avail), 64'd0);
    check("R5", "no overrun", 64'(rx_overrun), 64'd0);
  endtask

  task automatic t_overrun();
    put(3); tick();
    put(4); tick();
    check("R5", "overrun before drop", 64'(rx_overrun), 64'd0);
    put(5); tick();
    check("R5", "overrun after drop", 64'(rx_overrun), 64'd1);
    expect_head("R5", 3);
    rel_cmd = 1'b1; tick();
    expect_head("R5", 4);
    rel_cmd = 1'b1; tick();
    check("R5", "avail after drain", 64'(rx_avail), 64'd0);
    repeat (3) tick();
    check("R6", "sticky overrun", 64'(rx_overrun), 64'd1);
    clr_ovr_cmd = 1'b1; tick();
    check("R6", "overrun cleared", 64'(rx_overrun), 64'd0);
  endtask

  task automatic t_empty_release();
    rel_cmd = 1'b1; tick();
    check("R7", "avail", 64'(rx_avail), 64'd0);
    check("R7", "overrun", 64'(rx_overrun), 64'd0);
    put(6); tick();
    check("R7", "avail after write", 64'(rx_avail), 64'd1);
    expect_head("R7", 6);
    rel_cmd = 1'b1; tick();
    check("R7", "empty again", 64'(rx_avail), 64'd0);
  endtask

  task automatic t_swap();
    put(7); tick();
    put(8); tick();
    put(9); rel_cmd = 1'b1; tick();
    check("R8", "no overrun", 64'(rx_overrun), 64'd0);
    expect_head("R8", 8);
    rel_cmd = 1'b1; tick();
    expect_head("R8", 9);
    rel_cmd = 1'b1; tick();
    check("R8", "empty", 64'(rx_avail), 64'd0);
  endtask

  task automatic t_drop_vs_clear();
    put(10); tick();
    put(11); tick();
    put(12); clr_ovr_cmd = 1'b1; tick();
    check("R9", "drop beats clear", 64'(rx_overrun), 64'd1);
    expect_head("R9", 10);
    clr_ovr_cmd = 1'b1; tick();
    check("R6", "clear", 64'(rx_overrun), 64'd0);
    rel_cmd = 1'b1; tick();
    expect_head("R9", 11);
    rel_cmd = 1'b1; tick();
    check("R4", "drained", 64'(rx_avail), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_overrun();
    t_empty_release();
    t_swap();
    t_drop_vs_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule